// File: doc/BRIEF.md
# Address Signature Operations Unit

This block keeps a small bank of wide address signatures and the arithmetic that works on them. Each signature is a conservative set of addresses: a 32-bit address is scrambled by a fixed bit permutation, cut into four 8-bit fields, and each field sets exactly one bit in its own 256-bit slice of a 1024-bit register. Inserting an address ORs that pattern into the chosen register, so a register accumulates many addresses over time. A clear command empties a register in one cycle.

An operation port takes a command with two register selects and a probe address. It returns the intersection or union of two signatures, a null test on one signature, a membership test of the probe address, or a decode of a signature into a bitmask of the cache sets that could hold one of its addresses. Every result carries an empty flag. A signature counts as empty as soon as any one of its slices has no bit set, because then no address can match it. Results are conservative: a hit may be false, but an inserted address is never reported missing. The set-index bits of the address are kept unpermuted in the first field, so the set bitmask is that field's slice.

Top module: `sig_ops_unit`

## Requirements
- R1: After reset every register holds an empty signature, `res_valid` is 0 and `res_sig`, `res_empty` and `res_setmask` are 0.
- R2: The encoding of address a is built as follows. Field 0 is a[13:6] (SET_LO=6, 8 bits). The other 24 bits form o = {a[31:14], a[5:0]}, and bit k of o goes to permuted position 8 + ((7*k + 5) mod 24). Field f is the permuted bits [8f+7:8f], and it sets bit 256*f + field value. An insert ORs this encoding into the selected register. The new content is seen by commands issued from the next cycle on.
- R3: Opcode 0 (intersect) returns the bitwise AND of registers A and B.
- R4: Opcode 1 (union) returns the bitwise OR of registers A and B.
- R5: `res_empty` is 1 exactly when at least one 256-bit slice of `res_sig` is all zeros, even if other slices are not. Opcode 2 (null test) returns register A unchanged together with that flag.
- R6: Opcode 3 (membership) returns the encoding of `op_addr` ANDed with register A. It is a hit when `res_empty` is 0. An address inserted into A and not cleared since is always a hit.
- R7: Opcode 4 (decode) returns register A. `res_setmask` is slice 0 of A, and bit s set means cache set s may hold an address of the signature. For all other opcodes `res_setmask` is 0.
- R8: A clear makes the selected register empty. If an insert and a clear name the same register in the same cycle, the register ends up empty.
- R9: A result appears one cycle after its command, with `res_valid` high for that one cycle. Commands read register contents from before any insert or clear in the same cycle. Opcodes 5 to 7 produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert `ins_addr` into register `ins_sel` |
| ins_sel | input | 2 | Insert target register |
| ins_addr | input | 32 | Address to insert |
| clr_valid | input | 1 | Clear register `clr_sel` |
| clr_sel | input | 2 | Clear target register |
| op_valid | input | 1 | Issue command `op_code` |
| op_code | input | 3 | 0 intersect, 1 union, 2 null test, 3 membership, 4 decode |
| op_sel_a | input | 2 | First operand register |
| op_sel_b | input | 2 | Second operand register |
| op_addr | input | 32 | Probe address for membership |
| res_valid | output | 1 | Result present |
| res_sig | output | 1024 | Result signature |
| res_empty | output | 1 | Result signature is empty |
| res_setmask | output | 256 | Possible cache sets (decode only) |

## Verification
The bench builds the unit with its default parameters: four registers, 32-bit addresses, four 8-bit fields and the set index at bit 6. With these values the full 1024-bit result can be compared against an encoding model written from R2. Addresses that share a set index but differ in every other field make an intersection with one live slice and three dead ones, which exercises the empty rule of R5. The small register count lets the bench hit same-register conflicts on purpose, where clear and insert race, or a command reads a register that is being written in the same cycle.

// File: rtl/sig_pkg.sv
// Shared command codes for the address signature unit.
// Assumes a 3-bit command field; codes above OP_DECODE are not used.
package sig_pkg;
    typedef enum logic [2:0] {
        OP_AND    = 3'd0,
        OP_OR     = 3'd1,
        OP_TEST   = 3'd2,
        OP_MEMBER = 3'd3,
        OP_DECODE = 3'd4
    } sig_op_e;

    // True for the command codes that produce a result.
    function automatic logic op_is_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction
endpackage

// File: rtl/sig_encoder.sv
// Hash-encodes one address into a signature.
// Field 0 is the unpermuted set index, addr[SET_LO +: FIELD_W]. The
// remaining bits are scattered by an affine index map, k -> (k*MUL+ADD)
// mod OTH_W. Each field then sets one bit of its own slice.
// Assumes ADDR_W == NFIELD*FIELD_W, 1 <= SET_LO, SET_LO+FIELD_W <= ADDR_W,
// and gcd(PERM_MUL, OTH_W) == 1 so that the map is a bijection.
module sig_encoder #(
    parameter int ADDR_W   = 32,
    parameter int FIELD_W  = 8,
    parameter int NFIELD   = 4,
    parameter int SET_LO   = 6,
    parameter int PERM_MUL = 7,
    parameter int PERM_ADD = 5
) (
    input  logic [ADDR_W-1:0]                  addr,
    output logic [NFIELD*(2**FIELD_W)-1:0]     sig
);
    localparam int SLICE = 2**FIELD_W;
    localparam int OTH_W = ADDR_W - FIELD_W;

    logic [OTH_W-1:0]  oth;
    logic [ADDR_W-1:0] perm;

    // Build the permuted address: set index first, the rest scattered.
    always_comb begin
        oth  = {addr[ADDR_W-1:SET_LO+FIELD_W], addr[SET_LO-1:0]};
        perm = '0;
        perm[FIELD_W-1:0] = addr[SET_LO +: FIELD_W];
        for (int k = 0; k < OTH_W; k++) begin
            perm[FIELD_W + ((k*PERM_MUL + PERM_ADD) % OTH_W)] = oth[k];
        end
    end

    // One-hot decode of each field into its own slice.
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign sig[f*SLICE +: SLICE] = {{(SLICE-1){1'b0}}, 1'b1} << perm[f*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/sig_null_detect.sv
// Flags a signature as empty when any one slice has no bit set.
// Pure combinational; assumes slices are contiguous and equal in width.
module sig_null_detect #(
    parameter int NFIELD = 4,
    parameter int SLICE  = 256
) (
    input  logic [NFIELD*SLICE-1:0] sig,
    output logic                    empty
);
    logic [NFIELD-1:0] live;

    // A slice is live when at least one of its bits is set.
    for (genvar f = 0; f < NFIELD; f++) begin : g_slice
        assign live[f] = |sig[f*SLICE +: SLICE];
    end

    assign empty = ~&live;
endmodule

// File: rtl/sig_bank.sv
// Bank of signature registers with accumulate-insert and clear.
// Clear takes priority over an insert to the same register.
// Assumes NREG is a power of two, so every select value names a register.
module sig_bank #(
    parameter int NREG  = 4,
    parameter int SIG_W = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ins_valid,
    input  logic [$clog2(NREG)-1:0] ins_sel,
    input  logic [SIG_W-1:0]        ins_sig,
    input  logic                    clr_valid,
    input  logic [$clog2(NREG)-1:0] clr_sel,
    output logic [SIG_W-1:0]        bank_q [NREG]
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Per register: reset, then clear beats insert, insert ORs in.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[r] <= '0;
            end else if (clr_valid && clr_sel == r) begin
                bank_q[r] <= '0;
            end else if (ins_valid && ins_sel == r) begin
                bank_q[r] <= bank_q[r] | ins_sig;
            end
        end
    end
endmodule

// File: rtl/sig_ops_unit.sv
// Address signature operations unit: a register bank with insert and
// clear ports, plus one command port for intersect, union, null test,
// membership and set decode. Results are registered (one-cycle latency).
// Commands see bank contents from before same-cycle updates.
module sig_ops_unit #(
    parameter int ADDR_W   = 32,
    parameter int FIELD_W  = 8,
    parameter int NFIELD   = 4,
    parameter int NREG     = 4,
    parameter int SET_LO   = 6,
    parameter int PERM_MUL = 7,
    parameter int PERM_ADD = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ins_valid,
    input  logic [$clog2(NREG)-1:0]           ins_sel,
    input  logic [ADDR_W-1:0]                 ins_addr,
    input  logic                              clr_valid,
    input  logic [$clog2(NREG)-1:0]           clr_sel,
    input  logic                              op_valid,
    input  logic [2:0]                        op_code,
    input  logic [$clog2(NREG)-1:0]           op_sel_a,
    input  logic [$clog2(NREG)-1:0]           op_sel_b,
    input  logic [ADDR_W-1:0]                 op_addr,
    output logic                              res_valid,
    output logic [NFIELD*(2**FIELD_W)-1:0]    res_sig,
    output logic                              res_empty,
    output logic [(2**FIELD_W)-1:0]           res_setmask
);
    import sig_pkg::*;

    localparam int SLICE = 2**FIELD_W;
    localparam int SIG_W = NFIELD * SLICE;

    logic [SIG_W-1:0] ins_sig;
    logic [SIG_W-1:0] probe_sig;
    logic [SIG_W-1:0] bank_q [NREG];
    logic [SIG_W-1:0] opa, opb, calc_sig;
    logic [SLICE-1:0] calc_mask;
    logic             calc_empty;
    logic             issue;

    sig_encoder #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .NFIELD(NFIELD),
        .SET_LO(SET_LO), .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)
    ) u_enc_ins (
        .addr (ins_addr),
        .sig  (ins_sig)
    );

    sig_encoder #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .NFIELD(NFIELD),
        .SET_LO(SET_LO), .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD)
    ) u_enc_probe (
        .addr (op_addr),
        .sig  (probe_sig)
    );

    sig_bank #(
        .NREG(NREG), .SIG_W(SIG_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .ins_sel   (ins_sel),
        .ins_sig   (ins_sig),
        .clr_valid (clr_valid),
        .clr_sel   (clr_sel),
        .bank_q    (bank_q)
    );

    assign issue = op_valid && op_is_legal(op_code);
    assign opa   = bank_q[op_sel_a];
    assign opb   = bank_q[op_sel_b];

    // Select the result signature and set mask for the current command.
    always_comb begin
        calc_mask = '0;
        case (sig_op_e'(op_code))
            OP_AND:    calc_sig = opa & opb;
            OP_OR:     calc_sig = opa | opb;
            OP_TEST:   calc_sig = opa;
            OP_MEMBER: calc_sig = probe_sig & opa;
            OP_DECODE: begin
                calc_sig  = opa;
                calc_mask = opa[SLICE-1:0];
            end
            default:   calc_sig = '0;
        endcase
    end

    sig_null_detect #(
        .NFIELD(NFIELD), .SLICE(SLICE)
    ) u_null (
        .sig   (calc_sig),
        .empty (calc_empty)
    );

    // Register the result; outputs are zero in cycles without a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_sig     <= '0;
            res_empty   <= 1'b0;
            res_setmask <= '0;
        end else begin
            res_valid   <= issue;
            res_sig     <= issue ? calc_sig : '0;
            res_empty   <= issue && calc_empty;
            res_setmask <= issue ? calc_mask : '0;
        end
    end
endmodule

// File: rtl/sig_ops_chk.sv
// Checker for sig_ops_unit: result timing, clear behaviour and the
// no-missed-member guarantee. Attached by the bind at the end of the file.
module sig_ops_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 4,
    parameter int SIG_W  = 1024
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ins_valid,
    input logic [$clog2(NREG)-1:0] ins_sel,
    input logic [ADDR_W-1:0]       ins_addr,
    input logic                    clr_valid,
    input logic [$clog2(NREG)-1:0] clr_sel,
    input logic                    op_valid,
    input logic [2:0]              op_code,
    input logic [$clog2(NREG)-1:0] op_sel_a,
    input logic [ADDR_W-1:0]       op_addr,
    input logic                    res_valid,
    input logic                    res_empty,
    input logic [SIG_W-1:0]        bank_q [NREG]
);
    // R9: a legal command gives a result in the next cycle.
    p_result_follows_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4) |=> res_valid);

    // R9: no result without a legal command one cycle earlier.
    p_no_spurious_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code <= 3'd4) |=> !res_valid);

    // R8: a clear (even racing an insert) leaves the register empty.
    p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_valid)) |-> bank_q[$past(clr_sel)] == '0);

    // R6: membership right after an insert of the same address is a hit.
    p_member_after_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ins_valid)
         && !($past(clr_valid) && $past(clr_sel) == $past(ins_sel))
         && op_valid && op_code == 3'd3
         && op_sel_a == $past(ins_sel) && op_addr == $past(ins_addr))
        |=> (res_valid && !res_empty));
endmodule

bind sig_ops_unit sig_ops_chk #(
    .ADDR_W(ADDR_W), .NREG(NREG), .SIG_W(NFIELD*(2**FIELD_W))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_sel   (ins_sel),
    .ins_addr  (ins_addr),
    .clr_valid (clr_valid),
    .clr_sel   (clr_sel),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_sel_a  (op_sel_a),
    .op_addr   (op_addr),
    .res_valid (res_valid),
    .res_empty (res_empty),
    .bank_q    (bank_q)
);

// File: tb/tb_sig_ops_unit.sv
// Scoreboard bench: the driver computes expected results from a model of
// the requirements and queues them; the monitor compares on results.
module tb_sig_ops_unit;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [1:0]    ins_sel = '0;
    logic [31:0]   ins_addr = '0;
    logic          clr_valid = 1'b0;
    logic [1:0]    clr_sel = '0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [1:0]    op_sel_a = '0;
    logic [1:0]    op_sel_b = '0;
    logic [31:0]   op_addr = '0;
    logic          res_valid;
    logic [1023:0] res_sig;
    logic          res_empty;
    logic [255:0]  res_setmask;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1023:0] sig;
        logic          empty;
        logic [255:0]  mask;
        string         req;
    } exp_t;

    exp_t          sb[$];
    logic [1023:0] mbank [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_ops_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_sel(ins_sel), .ins_addr(ins_addr),
        .clr_valid(clr_valid), .clr_sel(clr_sel),
        .op_valid(op_valid), .op_code(op_code), .op_sel_a(op_sel_a),
        .op_sel_b(op_sel_b), .op_addr(op_addr),
        .res_valid(res_valid), .res_sig(res_sig), .res_empty(res_empty),
        .res_setmask(res_setmask)
    );

    // R2 encoding model, written from the requirement text.
    function automatic logic [1023:0] enc(input logic [31:0] a);
        logic [23:0]   o;
        logic [31:0]   p;
        logic [1023:0] s;
        o = {a[31:14], a[5:0]};
        p = '0;
        p[7:0] = a[13:6];
        for (int k = 0; k < 24; k++) p[8 + ((7*k + 5) % 24)] = o[k];
        s = '0;
        for (int f = 0; f < 4; f++) s[256*f + int'(p[8*f +: 8])] = 1'b1;
        return s;
    endfunction

    // R5 empty rule model.
    function automatic logic is_empty(input logic [1023:0] s);
        for (int f = 0; f < 4; f++) if (s[256*f +: 256] == '0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input logic ok, input string req, input logic [1023:0] act,
                         input logic [1023:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; queues the expected result and
    // then updates the model bank (clear beats insert, R8).
    task automatic drive(input logic iv, input logic [1:0] is, input logic [31:0] ia,
                         input logic cv, input logic [1:0] cs,
                         input logic ov, input logic [2:0] oc, input logic [1:0] sa,
                         input logic [1:0] sb_sel, input logic [31:0] oa, input string req);
        exp_t e;
        ins_valid = iv; ins_sel = is; ins_addr = ia;
        clr_valid = cv; clr_sel = cs;
        op_valid = ov; op_code = oc; op_sel_a = sa; op_sel_b = sb_sel; op_addr = oa;
        if (ov && oc <= 3'd4) begin
            e.mask = '0;
            case (oc)
                3'd0: e.sig = mbank[sa] & mbank[sb_sel];
                3'd1: e.sig = mbank[sa] | mbank[sb_sel];
                3'd2: e.sig = mbank[sa];
                3'd3: e.sig = enc(oa) & mbank[sa];
                default: begin
                    e.sig  = mbank[sa];
                    e.mask = mbank[sa][255:0];
                end
            endcase
            e.empty = is_empty(e.sig);
            e.req = req;
            sb.push_back(e);
        end
        if (cv) mbank[cs] = '0;
        if (iv && !(cv && cs == is)) mbank[is] = mbank[is] | enc(ia);
        @(negedge clk);
        ins_valid = 1'b0; clr_valid = 1'b0; op_valid = 1'b0;
    endtask

    task automatic ins(input logic [1:0] r, input logic [31:0] a);
        drive(1'b1, r, a, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 32'd0, "R2");
    endtask

    task automatic op(input logic [2:0] c, input logic [1:0] a, input logic [1:0] b,
                      input logic [31:0] pa, input string req);
        drive(1'b0, 2'd0, 32'd0, 1'b0, 2'd0, 1'b1, c, a, b, pa, req);
    endtask

    // Monitor: pops and compares each result as it appears.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected result", {1023'd0, res_valid}, 1024'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_sig == e.sig, {e.req, " sig"}, res_sig, e.sig);
                check(res_empty == e.empty, {e.req, " empty"}, {1023'd0, res_empty}, {1023'd0, e.empty});
                check(res_setmask == e.mask, {e.req, " mask"}, {768'd0, res_setmask}, {768'd0, e.mask});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] addrs [20];
        logic [31:0] x, y;
        for (int r = 0; r < 4; r++) mbank[r] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs after reset.
        check(res_valid == 1'b0 && res_sig == '0 && res_empty == 1'b0 && res_setmask == '0,
              "R1 reset outputs", {1023'd0, res_valid}, 1024'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every register empty after reset.
        for (int r = 0; r < 4; r++) op(3'd2, 2'(r), 2'd0, 32'd0, "R1");
        @(negedge clk);

        // R2/R6: insert then membership, back to back.
        ins(2'd0, 32'h1234_5678);
        op(3'd3, 2'd0, 2'd0, 32'h1234_5678, "R6 hit");
        op(3'd3, 2'd0, 2'd0, 32'hCAFE_0000, "R6 other");
        // R2: full signature of a single address.
        op(3'd2, 2'd0, 2'd0, 32'd0, "R2 encode");

        // R3/R4/R5: same set index, all other fields different -> one live slice.
        x = 32'h0000_0000 | (32'd37 << 6);
        y = 32'hFFFF_C03F | (32'd37 << 6);
        ins(2'd1, x);
        ins(2'd2, y);
        op(3'd0, 2'd1, 2'd2, 32'd0, "R5 partial empty");
        op(3'd1, 2'd1, 2'd2, 32'd0, "R4 union");
        op(3'd0, 2'd0, 2'd1, 32'd0, "R3 intersect");
        op(3'd0, 2'd1, 2'd1, 32'd0, "R3 self");

        // R7: decode of a fresh register gives the set bit of its address.
        op(3'd4, 2'd1, 2'd0, 32'd0, "R7 decode");
        check(1'b1, "R7", 1024'd0, 1024'd0);
        @(negedge clk);
        // R7: direct check at the port.
        drive(1'b0, 2'd0, 32'd0, 1'b0, 2'd0, 1'b1, 3'd4, 2'd2, 2'd0, 32'd0, "R7 decode2");
        check(res_setmask == (256'd1 << 37), "R7 set index", {768'd0, res_setmask}, {768'd0, 256'd1 << 37});

        // R9: command reads register before a same-cycle insert.
        drive(1'b1, 2'd3, 32'hAAAA_5555, 1'b0, 2'd0, 1'b1, 3'd2, 2'd3, 2'd0, 32'd0, "R9 old value");
        op(3'd2, 2'd3, 2'd0, 32'd0, "R9 new value");

        // R8: clear and insert to the same register: clear wins.
        drive(1'b1, 2'd0, 32'h0BAD_F00D, 1'b1, 2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 32'd0, "R8");
        op(3'd2, 2'd0, 2'd0, 32'd0, "R8 clear wins");
        check(res_sig == '0 && res_empty == 1'b1, "R8 cleared", res_sig, 1024'd0);

        // R9: undefined opcodes give no result.
        op(3'd5, 2'd1, 2'd2, 32'd0, "R9");
        check(res_valid == 1'b0, "R9 opcode 5", {1023'd0, res_valid}, 1024'd0);
        op(3'd7, 2'd1, 2'd2, 32'd0, "R9");
        check(res_valid == 1'b0, "R9 opcode 7", {1023'd0, res_valid}, 1024'd0);

        // R6: many inserts, every inserted address still hits.
        drive(1'b0, 2'd0, 32'd0, 1'b1, 2'd3, 1'b0, 3'd0, 2'd0, 2'd0, 32'd0, "R8");
        for (int i = 0; i < 20; i++) begin
            addrs[i] = $urandom;
            ins(2'd3, addrs[i]);
        end
        for (int i = 0; i < 20; i++) begin
            op(3'd3, 2'd3, 2'd0, addrs[i], "R6 no miss");
            check(res_valid && !res_empty, "R6 inserted hit", {1023'd0, res_empty}, 1024'd0);
        end
        op(3'd4, 2'd3, 2'd0, 32'd0, "R7 decode many");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9 results drained", 1024'(sb.size()), 1024'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule